// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause-22 MDIO master that software runs through a small 32-bit register port. One word holds the controller settings: run enable, mismatch-fault checking, the MDC divider, and the idle and fault status bits. A second word holds the command. It carries a start bit, the direction, the 5-bit register and PHY addresses, and a 16-bit data field.

Writing the command word with its start bit set launches one 64-bit management frame. The frame is a 32-bit preamble of ones, the start pattern `01`, and an opcode: `01` for a write, `10` for a read. Then come the PHY address, the register address, the turnaround and sixteen data bits, each field sent MSB first. MDC comes from the functional clock through the programmable divider. The start bit drops by itself when the frame ends.

On a read, the master releases the data line for the turnaround and the data phase. It shifts in the PHY's answer and reports through an acknowledge bit whether the PHY pulled the second turnaround bit low.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the settings word (address 0) reads 0x800000FF: idle set, divider 0xFF, all else 0. The command word (address 1) reads 0.
- R2: Settings word fields read back from the positions they are written to: divider at bits 15:0, fault-check enable at bit 18, fault at bit 19, run enable at bit 30, idle at bit 31 (read-only).
- R3: Command word layout: bit 31 start/busy, bit 30 direction (1 = write), bit 29 acknowledge, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. A command write with bit 31 set while enabled and idle starts a frame. Bit 31 reads 1 and idle reads 0 for exactly 128*(divider+1) clocks, after which bit 31 reads 0 and idle reads 1.
- R4: MDC is low whenever no frame runs. During a frame it toggles every divider+1 clocks and gives exactly 64 rising edges.
- R5: A write frame carries 32 ones, `01`, `01`, PHY address, register address, `10` and the 16 data bits, all driven by the master.
- R6: A read frame carries 32 ones, `01`, `10`, PHY address and register address, all driven by the master. From bit 46 (the first turnaround bit) to the end, the output enable stays low.
- R7: After a read, bit 29 is 1 exactly when the PHY drove bit 47 low, and bits 15:0 hold the 16 values sampled at the last 16 MDC rising edges, MSB first. After a write, bit 29 is 0 and the data field keeps the written value.
- R8: A command write while a frame runs is ignored: the running frame and the stored command fields are unchanged.
- R9: A start with run enable at 0 starts nothing. Clearing run enable during a frame stops it at once: bit 31 reads 0, idle reads 1, and MDC and the output enable are low.
- R10: The fault bit is set when fault checking is on and the line level sampled at an MDC rising edge differs from the level the master drives. It stays set until a settings write with bit 19 set, and is never set while fault checking is off.
- R11: The master changes its data output only while MDC is low, never while MDC stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 settings, 1 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line level seen at the pad |

## Verification
The bench builds the block with its default parameters: a 16-bit divider and a 2-bit register address. It sweeps divider values 0 to 3 over writes, acknowledged reads and unanswered reads with varied address and data patterns. One further frame runs at the reset divider of 0xFF. The small dividers keep every frame at 512 clocks or fewer, so exact frame lengths can be checked. They also bring in the case where MDC toggles on every clock, which is the tightest timing between a falling-edge update and the next rising-edge sample. A PHY model answers on the line, and fault injection flips the sampled level while the master drives.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int DATA_W     = 16;
  localparam int ADR_W      = 5;
  localparam int RELEASE_IX = 46;   // first turnaround bit
  localparam int ACK_IX     = 47;   // second turnaround bit
  localparam int DATA_IX    = 48;   // first data bit
  localparam int LAST_IX    = FRAME_BITS - 1;

  localparam int CTL_DIV_LSB = 0;
  localparam int CTL_FEN     = 18;
  localparam int CTL_FAULT   = 19;
  localparam int CTL_EN      = 30;
  localparam int CTL_IDLE    = 31;

  localparam int CMD_GO      = 31;
  localparam int CMD_WR      = 30;
  localparam int CMD_ACK     = 29;
  localparam int CMD_REG_LSB = 21;
  localparam int CMD_PHY_LSB = 16;

  typedef struct packed {
    logic              wr;
    logic [ADR_W-1:0]  regad;
    logic [ADR_W-1:0]  phy;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap     = run && (cnt_q >= div);
  assign rise_stb = wrap && !mdc_q;
  assign fall_stb = wrap &&  mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  mdio_cmd_t         cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              is_wr,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              mismatch,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack
);
  logic                  busy_q, busy_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [DATA_W-1:0]     rx_q, rx_d;
  logic                  ack_q, ack_d;
  logic                  wr_q, wr_d;
  logic [FRAME_BITS-1:0] frame;
  logic                  ce;

  assign frame = {{32{1'b1}}, 2'b01,
                  cmd.wr ? 2'b01 : 2'b10,
                  cmd.phy, cmd.regad,
                  cmd.wr ? 2'b10 : 2'b11,
                  cmd.wr ? cmd.data : {DATA_W{1'b1}}};

  assign ce = start | abort | (busy_q & (rise_stb | fall_stb));

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    sr_d   = sr_q;
    rx_d   = rx_q;
    ack_d  = ack_q;
    wr_d   = wr_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      bit_d  = '0;
      sr_d   = frame;
      rx_d   = '0;
      ack_d  = 1'b0;
      wr_d   = cmd.wr;
    end else if (busy_q) begin
      if (rise_stb) begin
        if (!wr_q && bit_q == BIT_W'(ACK_IX)) ack_d = !mdio_i;
        if (bit_q >= BIT_W'(DATA_IX))         rx_d  = {rx_q[DATA_W-2:0], mdio_i};
      end
      if (fall_stb) begin
        if (bit_q == BIT_W'(LAST_IX)) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
          sr_d  = {sr_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      sr_q   <= '1;
      rx_q   <= '0;
      ack_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (ce) begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      sr_q   <= sr_d;
      rx_q   <= rx_d;
      ack_q  <= ack_d;
      wr_q   <= wr_d;
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && fall_stb && (bit_q == BIT_W'(LAST_IX)) && !abort;
  assign is_wr    = wr_q;
  assign mdio_oe  = busy_q && (wr_q || bit_q < BIT_W'(RELEASE_IX));
  assign mdio_o   = busy_q ? sr_q[FRAME_BITS-1] : 1'b1;
  assign mismatch = rise_stb && mdio_oe && (mdio_i != mdio_o);
  assign rd_data  = rx_q;
  assign ack      = ack_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 'hFF,
  parameter int ADDR_W    = 2,
  parameter int CTL_ADDR  = 0,
  parameter int CMD_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int CTL_PAD = CTL_FEN - DIV_W;

  logic             rst_sn;
  logic             ctl_en_q, ctl_en_d;
  logic             ctl_fen_q, ctl_fen_d;
  logic             ctl_fault_q, ctl_fault_d;
  logic [DIV_W-1:0] ctl_div_q, ctl_div_d;
  mdio_cmd_t        acc_q, acc_d;
  logic             acc_ack_q, acc_ack_d;

  logic             ctl_wsel, acc_wsel, fault_clr;
  logic             start, abort, run;
  logic             busy, done, eng_wr, mismatch, eng_ack;
  logic             rise_stb, fall_stb;
  logic [DATA_W-1:0] eng_rd;
  logic [ADR_W*2:0] acc_hdr;
  mdio_cmd_t        new_cmd;

  mdio_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign ctl_wsel  = reg_wr && (reg_addr == ADDR_W'(CTL_ADDR));
  assign acc_wsel  = reg_wr && (reg_addr == ADDR_W'(CMD_ADDR));
  assign fault_clr = ctl_wsel && reg_wdata[CTL_FAULT];
  assign new_cmd   = '{wr:    reg_wdata[CMD_WR],
                       regad: reg_wdata[CMD_REG_LSB +: ADR_W],
                       phy:   reg_wdata[CMD_PHY_LSB +: ADR_W],
                       data:  reg_wdata[DATA_W-1:0]};
  assign start     = acc_wsel && !busy && ctl_en_q && reg_wdata[CMD_GO];
  assign abort     = busy && ctl_wsel && !reg_wdata[CTL_EN];
  assign run       = busy && !abort;
  assign acc_hdr   = {acc_q.wr, acc_q.regad, acc_q.phy};

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_sn), .run(run), .div(ctl_div_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_sn), .start(start), .abort(abort), .cmd(new_cmd),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .done(done), .is_wr(eng_wr), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mismatch(mismatch), .rd_data(eng_rd), .ack(eng_ack)
  );

  always_comb begin
    ctl_en_d    = ctl_en_q;
    ctl_fen_d   = ctl_fen_q;
    ctl_div_d   = ctl_div_q;
    ctl_fault_d = ctl_fault_q;
    acc_d       = acc_q;
    acc_ack_d   = acc_ack_q;
    if (ctl_wsel) begin
      ctl_en_d  = reg_wdata[CTL_EN];
      ctl_fen_d = reg_wdata[CTL_FEN];
      ctl_div_d = reg_wdata[CTL_DIV_LSB +: DIV_W];
    end
    if (fault_clr)            ctl_fault_d = 1'b0;
    if (ctl_fen_q && mismatch) ctl_fault_d = 1'b1;
    if (acc_wsel && !busy) begin
      acc_d     = new_cmd;
      acc_ack_d = 1'b0;
    end else if (done && !eng_wr) begin
      acc_d.data = eng_rd;
      acc_ack_d  = eng_ack;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctl_en_q    <= 1'b0;
      ctl_fen_q   <= 1'b0;
      ctl_fault_q <= 1'b0;
      ctl_div_q   <= DIV_W'(DIV_RESET);
      acc_q       <= '0;
      acc_ack_q   <= 1'b0;
    end else begin
      ctl_en_q    <= ctl_en_d;
      ctl_fen_q   <= ctl_fen_d;
      ctl_fault_q <= ctl_fault_d;
      ctl_div_q   <= ctl_div_d;
      acc_q       <= acc_d;
      acc_ack_q   <= acc_ack_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTL_ADDR)) begin
      reg_rdata[CTL_IDLE]             = !busy;
      reg_rdata[CTL_EN]               = ctl_en_q;
      reg_rdata[CTL_FAULT]            = ctl_fault_q;
      reg_rdata[CTL_FEN]              = ctl_fen_q;
      reg_rdata[CTL_DIV_LSB +: DIV_W] = ctl_div_q;
    end else if (reg_addr == ADDR_W'(CMD_ADDR)) begin
      reg_rdata[CMD_GO]                   = busy;
      reg_rdata[CMD_WR]                   = acc_q.wr;
      reg_rdata[CMD_ACK]                  = acc_ack_q;
      reg_rdata[CMD_REG_LSB +: ADR_W]     = acc_q.regad;
      reg_rdata[CMD_PHY_LSB +: ADR_W]     = acc_q.phy;
      reg_rdata[DATA_W-1:0]               = acc_q.data;
    end
  end

  logic unused_pad;
  assign unused_pad = (CTL_PAD < 0);
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        ctl_en,
  input logic        fault,
  input logic        fault_clr,
  input logic        acc_wsel,
  input logic        go_bit,
  input logic [10:0] acc_hdr
);
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wsel && go_bit && ctl_en && !busy) |=> busy);

  p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_wsel) |=> $stable(acc_hdr));

  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !busy);

  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);

  p_data_stable_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .ctl_en(ctl_en_q), .fault(ctl_fault_q), .fault_clr(fault_clr),
  .acc_wsel(acc_wsel), .go_bit(reg_wdata[31]), .acc_hdr(acc_hdr)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_en = 1'b0, phy_val = 1'b1, respond = 1'b0, inject = 1'b0;
  logic        rd_mode = 1'b0;
  logic [15:0] phy_data = '0;
  logic [63:0] cap = '0;
  int          rcnt = 0, oe_bad = 0, stab_bad = 0;
  int          n_chk = 0, n_bad = 0;
  logic        prev_mdc = 1'b0, prev_o = 1'b1;

  wire line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);
  assign mdio_i = line ^ (inject & mdio_oe);

  mdio_mgmt_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: records the line at each MDC rise, answers reads after falls
  always @(posedge mdc) begin
    if (rd_mode && rcnt >= 46 && mdio_oe) oe_bad++;
    cap = {cap[62:0], line};
    rcnt++;
  end

  always @(negedge mdc) begin
    if (respond && rcnt >= 47 && rcnt <= 63) begin
      phy_en  = 1'b1;
      phy_val = (rcnt == 47) ? 1'b0 : phy_data[63-rcnt];
    end else begin
      phy_en = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mdc && prev_mdc && mdio_o !== prev_o) stab_bad++;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1;
    #1;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd1;
    #1;
  endtask

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg, 2'b10, d};
  endfunction

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (reg_rdata[31] && cyc < 100000) begin
      cyc++;
      @(negedge clk); #1;
    end
  endtask

  task automatic frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input bit resp, input int div);
    int cyc;
    logic [63:0] ef;
    logic [31:0] acc;
    cap = '0; rcnt = 0; oe_bad = 0; rd_mode = !wr; respond = resp; phy_data = d;
    wr_reg(2'd1, {1'b1, wr, 1'b0, 3'b0, rg, phy, d});
    wait_idle(cyc);
    ef = exp_frame(wr, phy, rg, d);
    chk(cyc == 128 * (div + 1), "R3 frame length", cyc, 128 * (div + 1));
    chk(rcnt == 64, "R4 MDC rising edges", rcnt, 64);
    rd_reg(2'd1, acc);
    if (wr) begin
      chk(cap == ef, "R5 write frame bits", cap[31:0], ef[31:0]);
      chk(acc[29:0] == {1'b0, 3'b0, rg, phy, d}, "R7 write leaves ack 0 and fields", acc, {2'b01, 1'b0, 3'b0, rg, phy, d});
    end else begin
      chk(cap[63:18] == ef[63:18], "R6 read frame header", cap[63:32], ef[63:32]);
      chk(oe_bad == 0, "R6 released after bit 46", oe_bad, 0);
      if (resp)
        chk(acc[29] && acc[15:0] == d, "R7 acknowledged read data", acc, {16'h2000, d});
      else
        chk(!acc[29] && acc[15:0] == 16'hFFFF, "R7 no acknowledge", acc, 32'h0000_FFFF);
    end
    respond = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd_reg(2'd0, v); chk(v == 32'h8000_00FF, "R1 settings reset", v, 32'h8000_00FF);
    rd_reg(2'd1, v); chk(v == 32'h0, "R1 command reset", v, 32'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R4 idle MDC and enable low", {mdc, mdio_oe}, 0);

    wr_reg(2'd0, 32'h4004_0003);
    rd_reg(2'd0, v); chk(v == 32'hC004_0003, "R2 settings readback", v, 32'hC004_0003);

    // divider sweep
    for (int div = 0; div < 4; div++) begin
      wr_reg(2'd0, 32'h4000_0000 | div);
      for (int p = 0; p < 3; p++) begin
        logic [4:0] phy, rg;
        logic [15:0] d;
        phy = 5'((div * 11 + p * 5 + 1) % 32);
        rg  = 5'((div * 7 + p * 13 + 31) % 32);
        d   = 16'hA5C3 ^ 16'(div << 8) ^ 16'(p * 16'h1111);
        if (p == 2) begin phy = 5'h1F; rg = 5'h00; d = 16'h0000; end
        frame(1'b1, phy, rg, d, 1'b0, div);
        frame(1'b0, rg, phy, ~d, 1'b1, div);
        if (p == 0) frame(1'b0, phy, rg, d, 1'b0, div);
      end
    end

    // reset divider
    wr_reg(2'd0, 32'h4000_00FF);
    frame(1'b0, 5'h0A, 5'h15, 16'h8001, 1'b1, 255);

    // command while busy is ignored
    wr_reg(2'd0, 32'h4000_0001);
    cap = '0; rcnt = 0; rd_mode = 1'b0;
    wr_reg(2'd1, {3'b110, 3'b0, 5'h09, 5'h05, 16'h1234});
    repeat (20) @(negedge clk);
    wr_reg(2'd1, {3'b100, 3'b0, 5'h11, 5'h1E, 16'hBEEF});
    chk(reg_rdata[31] && reg_rdata[30:0] == {2'b10, 3'b0, 5'h09, 5'h05, 16'h1234},
        "R8 fields unchanged by busy write", reg_rdata, {3'b110, 3'b0, 5'h09, 5'h05, 16'h1234});
    wait_idle(cyc);
    chk(cyc == 256 - 22, "R8 running frame not restarted", cyc, 256 - 22);
    chk(cap == exp_frame(1'b1, 5'h05, 5'h09, 16'h1234), "R8 original frame sent", cap[31:0], 32'h0);

    // enable gating and abort
    wr_reg(2'd0, 32'h0000_0001);
    wr_reg(2'd1, {3'b110, 3'b0, 5'h03, 5'h04, 16'h5555});
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); #1;
        if (reg_rdata[31] || mdc) bad++;
      end
      chk(bad == 0, "R9 no start while disabled", bad, 0);
    end
    rd_reg(2'd0, v); chk(v[31] == 1'b1, "R9 idle while disabled", v, 32'h8000_0001);
    wr_reg(2'd0, 32'h4000_0001);
    wr_reg(2'd1, {3'b100, 3'b0, 5'h03, 5'h04, 16'h5555});
    repeat (30) @(negedge clk);
    wr_reg(2'd0, 32'h0000_0001);
    chk(reg_rdata[31] == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0, "R9 abort stops frame",
        {reg_rdata[31], mdc, mdio_oe}, 0);
    rd_reg(2'd0, v); chk(v[31] == 1'b1, "R9 idle after abort", v, 32'h8000_0001);

    // fault detection
    wr_reg(2'd0, 32'h4004_0001);
    inject = 1'b1;
    frame(1'b1, 5'h02, 5'h03, 16'hF0F0, 1'b0, 1);
    inject = 1'b0;
    rd_reg(2'd0, v); chk(v[19] == 1'b1, "R10 fault set", v, 32'hC00C_0001);
    frame(1'b1, 5'h02, 5'h03, 16'h0F0F, 1'b0, 1);
    rd_reg(2'd0, v); chk(v[19] == 1'b1, "R10 fault sticky", v, 32'hC00C_0001);
    wr_reg(2'd0, 32'h400C_0001);
    rd_reg(2'd0, v); chk(v[19] == 1'b0, "R10 fault cleared", v, 32'hC004_0001);
    wr_reg(2'd0, 32'h4000_0001);
    inject = 1'b1;
    frame(1'b1, 5'h06, 5'h07, 16'h1357, 1'b0, 1);
    inject = 1'b0;
    rd_reg(2'd0, v); chk(v[19] == 1'b0, "R10 no fault when checking off", v, 32'hC000_0001);

    chk(stab_bad == 0, "R11 data stable while MDC high", stab_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule